// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This engine moves the data phase of a memory-card transfer between system memory and the card's byte-wide data stream. Memory holds a chain of descriptors. Each descriptor is four 32-bit words. The engine starts when a data command is launched, and it begins the walk at the list base address. For each descriptor it reads the four words and computes how many bytes the descriptor covers. It then moves those bytes, either from memory to the card (write direction) or from the card to memory (read direction). Last, it writes the status word back with the ownership bit cleared, so that software can reclaim the descriptor.

The walk stops in either of two cases: a descriptor carries the last flag, or the running byte count reaches zero. On completion the engine raises a one-cycle group of set strobes that the surrounding register file ORs into its raw-interrupt and DMA-status registers. Memory traffic uses a single word-wide request/acknowledge port. The card side uses two valid/ready byte streams, one for each direction.

Top module: `chdma_engine`

## Requirements
- R1: A descriptor is read as four words from consecutive word addresses, starting at the descriptor address and in this order: status, buffer size, buffer address, next-descriptor address. The first descriptor address is `list_base`.
- R2: A `start` pulse has no effect in any of these cases: `dma_enable` is low, `byte_count` is zero, `block_size` is zero, or the direction is read (`dir_write`=0) while `card_ready` is low. In each case no memory request is issued and no completion strobe is produced.
- R3: A size field of zero selects `MAX_DESC_BYTES`. A size field larger than `MAX_DESC_BYTES` is clamped to `MAX_DESC_BYTES`.
- R4: A descriptor moves the smaller of its effective size and the remaining byte count.
- R5: Bits [1:0] of the buffer address are ignored. Every buffer access uses a word-aligned address, and successive words of one buffer are 4 bytes apart.
- R6: After its data has moved, a descriptor's status word is written back to the descriptor address with bit 31 (ownership) cleared and every other bit unchanged.
- R7: The next descriptor is read from the next-descriptor word. The walk ends after a descriptor whose status bit 2 (last) is set, or after the remaining byte count reaches zero. No further descriptor is fetched in either case.
- R8: Byte order is little-endian. Byte k of a transfer within a word is bits [8k+7:8k]. In the read direction, a final partial word is written with byte enables set only for the lanes that hold received bytes.
- R9: Completion produces a single-cycle pulse on `evt_data_done`, `evt_sdio` and `evt_summary`. In the same cycle `evt_tx_done` pulses for the write direction or `evt_rx_done` pulses for the read direction, never both.
- R10: Once `mem_req` is raised, it stays high with stable address and write enable until the cycle in which `mem_ack` is high.
- R11: After reset the engine is idle. `busy`, `mem_req`, `tx_valid` and `rx_ready` are low, and `bytes_left` is zero.
- R12: `bytes_left` is loaded from `byte_count` at start. It is reduced by each descriptor's moved bytes when that descriptor's status is written back, and it never grows during a walk.
- R13: Only the stream of the selected direction is active. `tx_valid` and `rx_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Data command launched |
| dma_enable | input | 1 | DMA enable from global control |
| dir_write | input | 1 | 1 = memory to card, 0 = card to memory |
| card_ready | input | 1 | Card has read data available |
| byte_count | input | CNT_W | Total bytes of the transfer |
| block_size | input | CNT_W | Block size; only checked for zero |
| list_base | input | ADDR_W | Address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte to card valid |
| tx_data | output | 8 | Byte to card |
| tx_ready | input | 1 | Card accepts byte |
| rx_valid | input | 1 | Byte from card valid |
| rx_data | input | 8 | Byte from card |
| rx_ready | output | 1 | Engine accepts byte |
| busy | output | 1 | Walk in progress |
| bytes_left | output | CNT_W | Remaining byte count |
| evt_data_done | output | 1 | Set strobe: data complete |
| evt_sdio | output | 1 | Set strobe: SDIO status |
| evt_summary | output | 1 | Set strobe: DMA summary |
| evt_tx_done | output | 1 | Set strobe: transmit done |
| evt_rx_done | output | 1 | Set strobe: receive done |

## Verification
The assertions check the following on every cycle. Memory requests are held until acknowledged. A gated start leaves the engine idle. Status write-backs never carry the ownership bit. Buffer writes are word-aligned. The completion strobes last one cycle and name exactly one direction. The remaining count never grows. The two streams are never active together.

Other behaviour is visible only in the bench's scenarios, because it depends on memory contents. These are the fetch order of the descriptor words, the clamp and zero-size substitution, byte order and the partial-word byte enables, the exact write-back values, and whether the walk stops at a last flag or at count exhaustion without touching the next descriptor.

// File: rtl/chdma_pkg.sv
package chdma_pkg;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int LANE_W         = $clog2(BYTES_PER_WORD);
    localparam int OWN_BIT        = 31;
    localparam int LAST_BIT       = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_MEM_RD,
        PH_SEND,
        PH_RECV,
        PH_MEM_WR,
        PH_WBACK,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/chdma_len.sv
module chdma_len #(
    parameter int CNT_W          = 32,
    parameter int MAX_DESC_BYTES = 8192
) (
    input  logic [31:0]      size_field,
    input  logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] move_bytes
);
    localparam int XW = (CNT_W > 32) ? CNT_W : 32;
    localparam logic [31:0] MAX_W = 32'(MAX_DESC_BYTES);

    logic [31:0] eff;
    logic [XW-1:0] eff_x, rem_x, pick_x;

    always_comb begin
        eff    = ((size_field == 32'd0) || (size_field > MAX_W)) ? MAX_W : size_field;
        eff_x  = XW'(eff);
        rem_x  = XW'(remaining);
        pick_x = (eff_x < rem_x) ? eff_x : rem_x;
        move_bytes = pick_x[CNT_W-1:0];
    end
endmodule

// File: rtl/chdma_lane.sv
module chdma_lane
    import chdma_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    output logic [7:0]        byte_out,
    output logic [WORD_W-1:0] word_out
);
    always_comb byte_out = word_in[8*lane +: 8];

    for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_lane
        assign word_out[8*g +: 8] = (lane == LANE_W'(g)) ? byte_in : word_in[8*g +: 8];
    end
endmodule

// File: rtl/chdma_engine.sv
module chdma_engine
    import chdma_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int CNT_W          = 32,
    parameter int MAX_DESC_BYTES = 8192
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      dma_enable,
    input  logic                      dir_write,
    input  logic                      card_ready,
    input  logic [CNT_W-1:0]          byte_count,
    input  logic [CNT_W-1:0]          block_size,
    input  logic [ADDR_W-1:0]         list_base,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [BYTES_PER_WORD-1:0] mem_be,
    output logic [WORD_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    input  logic                      tx_ready,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_data,
    output logic                      rx_ready,
    output logic                      busy,
    output logic [CNT_W-1:0]          bytes_left,
    output logic                      evt_data_done,
    output logic                      evt_sdio,
    output logic                      evt_summary,
    output logic                      evt_tx_done,
    output logic                      evt_rx_done
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES_PER_WORD - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BYTES_PER_WORD);

    typedef struct packed {
        phase_t                    ph;
        logic [1:0]                widx;
        logic [ADDR_W-1:0]         daddr;
        logic [WORD_W-1:0]         dstat;
        logic [WORD_W-1:0]         dsize;
        logic [ADDR_W-1:0]         dbuf;
        logic [ADDR_W-1:0]         dnext;
        logic [CNT_W-1:0]          left;
        logic [CNT_W-1:0]          move;
        logic [CNT_W-1:0]          pos;
        logic [ADDR_W-1:0]         woff;
        logic [WORD_W-1:0]         wbuf;
        logic [BYTES_PER_WORD-1:0] be;
        logic [LANE_W-1:0]         lane;
        logic                      wr;
    } eng_t;

    eng_t q, d;

    logic [CNT_W-1:0]  move_calc;
    logic [7:0]        lane_byte;
    logic [WORD_W-1:0] lane_word;
    logic [ADDR_W-1:0] buf_base;
    logic              go_ok;
    logic              in_wback;
    logic [CNT_W-1:0]  pos_inc;

    chdma_len #(
        .CNT_W         (CNT_W),
        .MAX_DESC_BYTES(MAX_DESC_BYTES)
    ) u_len (
        .size_field(q.dsize),
        .remaining (q.left),
        .move_bytes(move_calc)
    );

    chdma_lane u_lane (
        .word_in (q.wbuf),
        .lane    (q.lane),
        .byte_in (rx_data),
        .byte_out(lane_byte),
        .word_out(lane_word)
    );

    assign tx_data = lane_byte;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '1;
        tx_valid  = 1'b0;
        rx_ready  = 1'b0;
        in_wback  = 1'b0;
        buf_base  = {q.dbuf[ADDR_W-1:2], 2'b00};
        pos_inc   = q.pos + CNT_W'(1);
        go_ok     = dma_enable && (byte_count != '0) && (block_size != '0)
                    && (dir_write || card_ready);

        case (q.ph)
            PH_IDLE: begin
                if (start && go_ok) begin
                    d.ph    = PH_FETCH;
                    d.widx  = 2'd0;
                    d.daddr = list_base;
                    d.left  = byte_count;
                    d.wr    = dir_write;
                end
            end
            PH_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.daddr + ADDR_W'({q.widx, 2'b00});
                if (mem_ack) begin
                    d.widx = q.widx + 2'd1;
                    case (q.widx)
                        2'd0: d.dstat = mem_rdata;
                        2'd1: d.dsize = mem_rdata;
                        2'd2: d.dbuf  = mem_rdata[ADDR_W-1:0];
                        default: begin
                            d.dnext = mem_rdata[ADDR_W-1:0];
                            d.move  = move_calc;
                            d.pos   = '0;
                            d.woff  = '0;
                            d.lane  = '0;
                            d.be    = '0;
                            d.wbuf  = '0;
                            d.ph    = q.wr ? PH_MEM_RD : PH_RECV;
                        end
                    endcase
                end
            end
            PH_MEM_RD: begin
                mem_req  = 1'b1;
                mem_addr = buf_base + q.woff;
                if (mem_ack) begin
                    d.wbuf = mem_rdata;
                    d.woff = q.woff + WORD_STEP;
                    d.lane = '0;
                    d.ph   = PH_SEND;
                end
            end
            PH_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    d.pos  = pos_inc;
                    d.lane = q.lane + LANE_W'(1);
                    if (pos_inc == q.move)
                        d.ph = PH_WBACK;
                    else if (q.lane == LAST_LANE)
                        d.ph = PH_MEM_RD;
                end
            end
            PH_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.wbuf       = lane_word;
                    d.be[q.lane] = 1'b1;
                    d.pos        = pos_inc;
                    d.lane       = q.lane + LANE_W'(1);
                    if ((pos_inc == q.move) || (q.lane == LAST_LANE))
                        d.ph = PH_MEM_WR;
                end
            end
            PH_MEM_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = buf_base + q.woff;
                mem_be   = q.be;
                if (mem_ack) begin
                    d.woff = q.woff + WORD_STEP;
                    d.wbuf = '0;
                    d.be   = '0;
                    d.lane = '0;
                    d.ph   = (q.pos == q.move) ? PH_WBACK : PH_RECV;
                end
            end
            PH_WBACK: begin
                in_wback = 1'b1;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.daddr;
                if (mem_ack) begin
                    d.left = q.left - q.move;
                    if (q.dstat[LAST_BIT] || (q.left == q.move)) begin
                        d.ph = PH_DONE;
                    end else begin
                        d.ph    = PH_FETCH;
                        d.daddr = q.dnext;
                        d.widx  = 2'd0;
                    end
                end
            end
            PH_DONE: d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase

        mem_wdata = in_wback ? (q.dstat & ~(WORD_W'(1) << OWN_BIT)) : q.wbuf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy          = (q.ph != PH_IDLE);
    assign bytes_left    = q.left;
    assign evt_data_done = (q.ph == PH_DONE);
    assign evt_sdio      = (q.ph == PH_DONE);
    assign evt_summary   = (q.ph == PH_DONE);
    assign evt_tx_done   = (q.ph == PH_DONE) && q.wr;
    assign evt_rx_done   = (q.ph == PH_DONE) && !q.wr;
endmodule

// File: rtl/chdma_engine_chk.sv
module chdma_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dma_enable,
    input logic              dir_write,
    input logic              card_ready,
    input logic [CNT_W-1:0]  byte_count,
    input logic [CNT_W-1:0]  block_size,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              own_bit_out,
    input logic              in_wback,
    input logic              tx_valid,
    input logic              rx_ready,
    input logic              busy,
    input logic [CNT_W-1:0]  bytes_left,
    input logic              evt_data_done,
    input logic              evt_sdio,
    input logic              evt_summary,
    input logic              evt_tx_done,
    input logic              evt_rx_done
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (!dma_enable || (byte_count == '0) || (block_size == '0)
                            || (!dir_write && !card_ready))) |=> !busy); // R2

    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wback && mem_req) |-> (mem_we && !own_bit_out)); // R6

    AST_BUF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !in_wback) |-> (mem_addr[1:0] == 2'b00)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_summary |=> !evt_summary); // R9

    AST_DONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_summary |-> ((evt_tx_done ^ evt_rx_done) && evt_data_done && evt_sdio)); // R9

    AST_LEFT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (bytes_left <= $past(bytes_left))); // R12

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready)); // R13
endmodule

bind chdma_engine chdma_engine_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dma_enable   (dma_enable),
    .dir_write    (dir_write),
    .card_ready   (card_ready),
    .byte_count   (byte_count),
    .block_size   (block_size),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .own_bit_out  (mem_wdata[31]),
    .in_wback     (in_wback),
    .tx_valid     (tx_valid),
    .rx_ready     (rx_ready),
    .busy         (busy),
    .bytes_left   (bytes_left),
    .evt_data_done(evt_data_done),
    .evt_sdio     (evt_sdio),
    .evt_summary  (evt_summary),
    .evt_tx_done  (evt_tx_done),
    .evt_rx_done  (evt_rx_done)
);

// File: tb/chdma_engine_test.sv
module chdma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dma_enable = 1'b0;
    logic        dir_write = 1'b0;
    logic        card_ready = 1'b0;
    logic [31:0] byte_count = '0;
    logic [31:0] block_size = '0;
    logic [31:0] list_base = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready;
    logic        busy;
    logic [31:0] bytes_left;
    logic        evt_data_done, evt_sdio, evt_summary, evt_tx_done, evt_rx_done;

    chdma_engine #(.ADDR_W(32), .CNT_W(32), .MAX_DESC_BYTES(16)) uut (.*);

    always #10 clk = ~clk;

    logic [31:0] mem [0:255];
    logic [31:0] addr_log [0:255];
    logic [7:0]  tx_log [0:63];
    int req_n = 0, tx_n = 0, rx_n = 0;
    int n_sum = 0, n_tx = 0, n_rx = 0, n_dd = 0, n_sdio = 0;
    int req_drop = 0, both_streams = 0;
    logic prev_req = 1'b0, prev_ack = 1'b0;
    logic rx_en = 1'b0;
    int checks = 0, failures = 0;
    bit finished = 0;

    assign rx_valid = rx_en;
    assign rx_data  = 8'hA0 + 8'(rx_n);

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            mem_ack  <= mem_req && !mem_ack;
            tx_ready <= ~tx_ready;
            if (mem_req && !mem_ack) begin
                addr_log[req_n[7:0]] <= mem_addr;
                req_n <= req_n + 1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we)
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            if (tx_valid && tx_ready) begin
                tx_log[tx_n[5:0]] <= tx_data;
                tx_n <= tx_n + 1;
            end
            if (rx_valid && rx_ready) rx_n <= rx_n + 1;
            if (evt_summary)   n_sum  <= n_sum + 1;
            if (evt_tx_done)   n_tx   <= n_tx + 1;
            if (evt_rx_done)   n_rx   <= n_rx + 1;
            if (evt_data_done) n_dd   <= n_dd + 1;
            if (evt_sdio)      n_sdio <= n_sdio + 1;
            if (prev_req && !prev_ack && !mem_req) req_drop <= req_drop + 1;
            if (tx_valid && rx_ready) both_streams <= both_streams + 1;
            prev_req <= mem_req;
            prev_ack <= mem_ack;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        check("R11 busy", 32'(busy), 0);
        check("R11 mem_req", 32'(mem_req), 0);
        check("R11 bytes_left", bytes_left, 0);
        check("R11 streams", {30'd0, tx_valid, rx_ready}, 0);
    endtask

    task automatic gated_case(input string tag, input logic en, input logic [31:0] cnt,
                              input logic [31:0] bs, input logic wr, input logic cr);
        int r0, s0;
        r0 = req_n; s0 = n_sum;
        dma_enable = en; byte_count = cnt; block_size = bs; dir_write = wr; card_ready = cr;
        pulse_start();
        repeat (10) @(negedge clk);
        check({"R2 no request ", tag}, 32'(req_n - r0), 0);
        check({"R2 idle ", tag}, 32'(busy), 0);
        check({"R2 no completion ", tag}, 32'(n_sum - s0), 0);
    endtask

    task automatic test_gating();
        gated_case("enable low", 1'b0, 32'd8, 32'd512, 1'b1, 1'b1);
        gated_case("count zero", 1'b1, 32'd0, 32'd512, 1'b1, 1'b1);
        gated_case("block zero", 1'b1, 32'd8, 32'd0, 1'b1, 1'b1);
        gated_case("read no data", 1'b1, 32'd8, 32'd512, 1'b0, 1'b0);
    endtask

    task automatic test_write_chain();
        int r0, t0, x0, s0, tr0, rr0, dd0, sd0;
        logic [7:0] exp_b [0:9];
        exp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
        mem[64] = 32'h8000_0018; mem[65] = 32'd6;  mem[66] = 32'h203; mem[67] = 32'h140;
        mem[80] = 32'h8000_0004; mem[81] = 32'd0;  mem[82] = 32'h300; mem[83] = 32'h3F0;
        mem[128] = 32'h4433_2211; mem[129] = 32'h8877_6655;
        mem[192] = 32'hDDCC_BBAA; mem[193] = 32'h1111_1111;
        r0 = req_n; t0 = tx_n; x0 = rx_n; s0 = n_sum; tr0 = n_tx; rr0 = n_rx; dd0 = n_dd; sd0 = n_sdio;
        dma_enable = 1'b1; byte_count = 32'd10; block_size = 32'd512; dir_write = 1'b1;
        card_ready = 1'b0; list_base = 32'h100;
        pulse_start();
        wait_idle();
        check("R1 fetch word0", addr_log[r0[7:0]], 32'h100);
        check("R1 fetch word1", addr_log[8'(r0 + 1)], 32'h104);
        check("R1 fetch word2", addr_log[8'(r0 + 2)], 32'h108);
        check("R1 fetch word3", addr_log[8'(r0 + 3)], 32'h10C);
        check("R5 aligned buffer read", addr_log[8'(r0 + 4)], 32'h200);
        check("R4 tx byte count", 32'(tx_n - t0), 10);
        for (int i = 0; i < 10; i++)
            check("R8 tx byte order", 32'(tx_log[6'(t0 + i)]), 32'(exp_b[i]));
        check("R6 writeback first", mem[64], 32'h0000_0018);
        check("R6 writeback second", mem[80], 32'h0000_0004);
        check("R12 bytes_left", bytes_left, 0);
        check("R9 summary pulses", 32'(n_sum - s0), 1);
        check("R9 tx_done pulses", 32'(n_tx - tr0), 1);
        check("R9 rx_done pulses", 32'(n_rx - rr0), 0);
        check("R9 data_done pulses", 32'(n_dd - dd0), 1);
        check("R9 sdio pulses", 32'(n_sdio - sd0), 1);
        check("R13 no rx in write", 32'(rx_n - x0), 0);
    endtask

    task automatic test_read_clamp();
        int x0, t0, rr0, tr0;
        mem[96]  = 32'h8000_0008; mem[97]  = 32'd0;    mem[98]  = 32'h280; mem[99]  = 32'h1A0;
        mem[104] = 32'h8000_0010; mem[105] = 32'd1000; mem[106] = 32'h2C0; mem[107] = 32'h1C0;
        mem[112] = 32'h8000_0000; mem[113] = 32'd12;   mem[114] = 32'h381; mem[115] = 32'h1E0;
        mem[120] = 32'h8000_0004; mem[121] = 32'd4;    mem[122] = 32'h000; mem[123] = 32'h000;
        for (int i = 224; i < 228; i++) mem[i] = 32'hEEEE_EEEE;
        x0 = rx_n; t0 = tx_n; rr0 = n_rx; tr0 = n_tx;
        dma_enable = 1'b1; byte_count = 32'd37; block_size = 32'd512; dir_write = 1'b0;
        card_ready = 1'b1; list_base = 32'h180;
        @(negedge clk) rx_en = 1'b1;
        pulse_start();
        wait_idle();
        rx_en = 1'b0;
        check("R3 zero size first word", mem[160], 32'hA3A2_A1A0);
        check("R3 zero size uses max", mem[163], 32'hAFAE_ADAC);
        check("R3 oversize clamped start", mem[176], 32'hB3B2_B1B0);
        check("R3 oversize clamped end", mem[179], 32'hBFBE_BDBC);
        check("R8 read packing", mem[224], 32'hC3C2_C1C0);
        check("R8 partial word enables", mem[225], 32'hEEEE_EEC4);
        check("R4 untouched beyond count", mem[226], 32'hEEEE_EEEE);
        check("R4 bytes received", 32'(rx_n - x0), 37);
        check("R6 writeback d0", mem[96], 32'h0000_0008);
        check("R6 writeback d1", mem[104], 32'h0000_0010);
        check("R6 writeback d2", mem[112], 32'h0000_0000);
        check("R7 count end leaves next", mem[120], 32'h8000_0004);
        check("R9 rx_done pulses", 32'(n_rx - rr0), 1);
        check("R9 tx_done pulses", 32'(n_tx - tr0), 0);
        check("R13 no tx in read", 32'(tx_n - t0), 0);
        check("R12 bytes_left", bytes_left, 0);
    endtask

    task automatic test_last_flag();
        int r0, t0;
        mem[16] = 32'h8000_0004; mem[17] = 32'd8; mem[18] = 32'h000; mem[19] = 32'h060;
        mem[24] = 32'h8000_0000; mem[25] = 32'd4; mem[26] = 32'h000; mem[27] = 32'h000;
        mem[0] = 32'h0403_0201; mem[1] = 32'h0807_0605;
        r0 = req_n; t0 = tx_n;
        dma_enable = 1'b1; byte_count = 32'd100; block_size = 32'd512; dir_write = 1'b1;
        card_ready = 1'b0; list_base = 32'h040;
        pulse_start();
        wait_idle();
        check("R7 last flag bytes", 32'(tx_n - t0), 8);
        check("R7 last flag request count", 32'(req_n - r0), 7);
        check("R7 next not touched", mem[24], 32'h8000_0000);
        check("R12 bytes_left after last", bytes_left, 92);
        check("R6 writeback last", mem[16], 32'h0000_0004);
        check("R8 last byte", 32'(tx_log[6'(t0 + 7)]), 32'h08);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_gating();
        test_write_chain();
        test_read_clamp();
        test_last_flag();
        check("R10 request never dropped", 32'(req_drop), 0);
        check("R13 streams exclusive", 32'(both_streams), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule